// File: doc/BRIEF.md
# BPSK Costas Carrier Recovery Loop

This block recovers the carrier phase of a binary phase-shift keyed signal that carries NRZ symbols. It accepts real-valued digitized samples on a valid/ready stream. Each accepted sample is mixed against the cosine and negated sine of a local numerically controlled oscillator, giving in-phase and quadrature products. Both arms are integrated over one symbol. The sample that carries the end-of-symbol flag closes the symbol and dumps both integrals. The phase detector error is the quadrature integral multiplied by the sign of the in-phase integral. A second-order loop filter steers the oscillator with this error. The filter has a proportional path and an integrator path, and each path has its own right-shift gain.

The two shift amounts range from 0 to 31. This lets the loop bandwidth be tuned across many decades without any multiplier in the filter. The nominal carrier is set by a frequency word. A lock detector sums the in-phase power minus the quadrature power over a programmable window of symbols and compares the sum against two thresholds, which gives hysteresis. For each symbol the block emits one result beat on an output stream: the soft in-phase value and the phase error. The lock flag is a plain level.

Back-pressure rules: the output holds one result. While that result is valid and not taken, the input stream is stalled. `s_ready` is high exactly when the output register is empty or is being drained in the same cycle. A beat on either stream transfers on a rising edge where its valid and ready are both high. The design supports symbol lengths of 1 to 4096 samples.

Top module: `costas_carrier_loop`

## Requirements
- R1: `s_ready` equals `!m_valid || m_ready`. A sample is consumed only on an edge with `s_valid && s_ready`. The edge that consumes a sample with `s_last` high makes `m_valid` high after that edge.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_soft_i` and `m_phase_err` hold their values and no sample is consumed.
- R3: The oscillator phase is a 32-bit accumulator that starts at 0. It advances only on a consumed sample, and the step is `freq_word` plus the loop correction (modulo 2^32).
- R4: The sine value at index k (the top 6 phase bits) is round(127*sin(2*pi*k/64)), with halves rounded away from zero. The cosine value is the sine value at index (k+16) mod 64.
- R5: The in-phase product is sample*cos and the quadrature product is -(sample*sin). Each arm sums the products of every sample in a symbol, including the flagged last sample. `m_soft_i` is the in-phase sum of that symbol.
- R6: `m_phase_err` equals the quadrature sum when the in-phase sum is zero or positive, and equals the negated quadrature sum when the in-phase sum is negative.
- R7: At each symbol end the proportional term becomes err>>>`kp_shift` and the integrator adds err>>>`ki_shift` (both are arithmetic shifts). The loop correction is proportional plus integrator. It applies from the next consumed sample onward.
- R8: Each symbol contributes (I>>>16)^2 - (Q>>>16)^2, where I and Q are the symbol sums. After `lock_len` symbols (0 acts as 1) the window total is checked. A total above `lock_hi` sets `locked`, a total below `lock_lo` clears it, and any other total leaves it unchanged. The window then restarts from zero.
- R9: `locked` changes only on an edge that closes a symbol, and the loop integrator also changes only on such an edge.
- R10: A synchronous active-high `rst` clears the phase, both arm sums, the proportional and integrator terms, the lock window, `locked` and `m_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Nominal oscillator phase step per sample |
| kp_shift | input | 5 | Proportional gain as a right shift |
| ki_shift | input | 5 | Integral gain as a right shift |
| lock_len | input | 8 | Symbols per lock window (0 acts as 1) |
| lock_hi | input | 41 | Signed upper lock threshold |
| lock_lo | input | 41 | Signed lower lock threshold |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_sample | input | 12 | Signed input sample |
| s_last | input | 1 | Sample is the last of its symbol |
| m_valid | output | 1 | Symbol result valid |
| m_ready | input | 1 | Symbol result ready |
| m_soft_i | output | 32 | Signed in-phase symbol sum |
| m_phase_err | output | 32 | Signed phase detector error |
| locked | output | 1 | Lock flag |

## Verification
Two events can fall on the same edge. One is a symbol dump that loads a new result while the consumer drains the previous one. The other is a lock-window closure that happens on that same dump. Bursts of one-sample symbols are sent with `m_ready` held high and a one-symbol lock window, so that every edge both loads and drains the output and re-decides the lock flag. A sample-level reference model in the bench predicts each result beat and the lock level that should accompany it. The scoreboard judges every beat against that prediction, so a lost, duplicated or stale beat shows up as a mismatch.

// File: rtl/costas_pkg.sv
package costas_pkg;
  // Fixed oscillator table geometry: 64 points per cycle, 8-bit signed
  localparam int LUT_BITS = 6;
  localparam int COEF_W   = 8;
  localparam logic [LUT_BITS-2:0] QTR = 5'd16;

  // One quarter of a sine cycle, 17 points including both ends
  function automatic logic signed [COEF_W-1:0] quarter_sine(input logic [LUT_BITS-2:0] j);
    logic signed [COEF_W-1:0] v;
    case (j)
      5'd0:  v = 8'sd0;
      5'd1:  v = 8'sd12;
      5'd2:  v = 8'sd25;
      5'd3:  v = 8'sd37;
      5'd4:  v = 8'sd49;
      5'd5:  v = 8'sd60;
      5'd6:  v = 8'sd71;
      5'd7:  v = 8'sd81;
      5'd8:  v = 8'sd90;
      5'd9:  v = 8'sd98;
      5'd10: v = 8'sd106;
      5'd11: v = 8'sd112;
      5'd12: v = 8'sd117;
      5'd13: v = 8'sd122;
      5'd14: v = 8'sd125;
      5'd15: v = 8'sd126;
      5'd16: v = 8'sd127;
      default: v = 8'sd0;
    endcase
    return v;
  endfunction

  // Full-cycle sine from quarter-wave symmetry
  function automatic logic signed [COEF_W-1:0] sine_at(input logic [LUT_BITS-1:0] k);
    logic [LUT_BITS-3:0] m;
    logic [LUT_BITS-2:0] j;
    logic signed [COEF_W-1:0] mag;
    m = k[LUT_BITS-3:0];
    j = k[LUT_BITS-2] ? (QTR - {1'b0, m}) : {1'b0, m};
    mag = quarter_sine(j);
    return k[LUT_BITS-1] ? -mag : mag;
  endfunction
endpackage

// File: rtl/costas_nco.sv
module costas_nco
  import costas_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_en,
  input  logic [PHASE_W-1:0]       step,
  output logic [PHASE_W-1:0]       phase,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  logic [LUT_BITS-1:0] idx;

  assign idx   = phase[PHASE_W-1 -: LUT_BITS];
  assign sin_o = sine_at(idx);
  assign cos_o = sine_at(idx + LUT_BITS'(QTR));

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (step_en) phase <= phase + step;
  end
endmodule

// File: rtl/costas_arms.sv
module costas_arms #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 8,
  parameter int INT_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       last,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [COEF_W-1:0]   cos_c,
  input  logic signed [COEF_W-1:0]   sin_c,
  output logic signed [INT_W-1:0]    sum_i,
  output logic signed [INT_W-1:0]    sum_q
);
  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic signed [PROD_W-1:0] prod_i, prod_s, prod_q;
  logic signed [INT_W-1:0]  acc_i, acc_q;

  assign prod_i = PROD_W'(sample) * PROD_W'(cos_c);
  assign prod_s = PROD_W'(sample) * PROD_W'(sin_c);
  assign prod_q = -prod_s;

  // Running sums include the sample presented this cycle
  assign sum_i = acc_i + INT_W'(prod_i);
  assign sum_q = acc_q + INT_W'(prod_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_i <= '0;
      acc_q <= '0;
    end else if (en) begin
      acc_i <= last ? '0 : sum_i;
      acc_q <= last ? '0 : sum_q;
    end
  end
endmodule

// File: rtl/costas_loop_filter.sv
module costas_loop_filter #(
  parameter int INT_W   = 32,
  parameter int PHASE_W = 32,
  parameter int SH_W    = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    update,
  input  logic signed [INT_W-1:0] err,
  input  logic [SH_W-1:0]         kp_shift,
  input  logic [SH_W-1:0]         ki_shift,
  output logic [PHASE_W-1:0]      correction,
  output logic [PHASE_W-1:0]      integ
);
  logic signed [INT_W-1:0]   p_sh, i_sh;
  logic signed [PHASE_W-1:0] prop_q, integ_q;

  assign p_sh = err >>> kp_shift;
  assign i_sh = err >>> ki_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      prop_q  <= '0;
      integ_q <= '0;
    end else if (update) begin
      prop_q  <= PHASE_W'(p_sh);
      integ_q <= integ_q + PHASE_W'(i_sh);
    end
  end

  assign correction = prop_q + integ_q;
  assign integ      = integ_q;
endmodule

// File: rtl/costas_lock_det.sv
module costas_lock_det #(
  parameter int INT_W = 32,
  parameter int PW    = 16,
  parameter int CNT_W = 8,
  parameter int LK_W  = 2*PW + 1 + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    update,
  input  logic signed [INT_W-1:0] sum_i,
  input  logic signed [INT_W-1:0] sum_q,
  input  logic [CNT_W-1:0]        win_len,
  input  logic signed [LK_W-1:0]  thr_hi,
  input  logic signed [LK_W-1:0]  thr_lo,
  output logic                    locked
);
  logic signed [PW-1:0]   pi, pq;
  logic signed [2*PW-1:0] sq_i, sq_q;
  logic signed [LK_W-1:0] diff, total, acc;
  logic [CNT_W-1:0]       cnt;
  logic                   win_end;

  assign pi    = $signed(sum_i[INT_W-1 -: PW]);
  assign pq    = $signed(sum_q[INT_W-1 -: PW]);
  assign sq_i  = (2*PW)'(pi) * (2*PW)'(pi);
  assign sq_q  = (2*PW)'(pq) * (2*PW)'(pq);
  assign diff  = LK_W'(sq_i) - LK_W'(sq_q);
  assign total = acc + diff;
  assign win_end = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, win_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      cnt    <= '0;
      locked <= 1'b0;
    end else if (update) begin
      if (win_end) begin
        acc <= '0;
        cnt <= '0;
        if (total > thr_hi)      locked <= 1'b1;
        else if (total < thr_lo) locked <= 1'b0;
      end else begin
        acc <= total;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/costas_carrier_loop.sv
module costas_carrier_loop
  import costas_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PHASE_W  = 32,
  parameter int SYM_LOG2 = 12,
  parameter int PW       = 16,
  parameter int CNT_W    = 8,
  parameter int SH_W     = 5,
  localparam int INT_W   = SAMPLE_W + COEF_W + SYM_LOG2,
  localparam int LK_W    = 2*PW + 1 + CNT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PHASE_W-1:0]         freq_word,
  input  logic [SH_W-1:0]            kp_shift,
  input  logic [SH_W-1:0]            ki_shift,
  input  logic [CNT_W-1:0]           lock_len,
  input  logic signed [LK_W-1:0]     lock_hi,
  input  logic signed [LK_W-1:0]     lock_lo,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_sample,
  input  logic                       s_last,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic signed [INT_W-1:0]    m_soft_i,
  output logic signed [INT_W-1:0]    m_phase_err,
  output logic                       locked
);
  logic                     accept, dump;
  logic [PHASE_W-1:0]       nco_phase, correction, loop_integ;
  logic signed [COEF_W-1:0] cos_c, sin_c;
  logic signed [INT_W-1:0]  sum_i, sum_q, err;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;
  assign dump    = accept && s_last;

  costas_nco #(.PHASE_W(PHASE_W)) u_nco (
    .clk, .rst,
    .step_en (accept),
    .step    (freq_word + correction),
    .phase   (nco_phase),
    .cos_o   (cos_c),
    .sin_o   (sin_c)
  );

  costas_arms #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .INT_W(INT_W)) u_arms (
    .clk, .rst,
    .en     (accept),
    .last   (s_last),
    .sample (s_sample),
    .cos_c, .sin_c,
    .sum_i, .sum_q
  );

  // Sign of I times Q
  assign err = sum_i[INT_W-1] ? -sum_q : sum_q;

  costas_loop_filter #(.INT_W(INT_W), .PHASE_W(PHASE_W), .SH_W(SH_W)) u_filt (
    .clk, .rst,
    .update     (dump),
    .err,
    .kp_shift, .ki_shift,
    .correction,
    .integ      (loop_integ)
  );

  costas_lock_det #(.INT_W(INT_W), .PW(PW), .CNT_W(CNT_W), .LK_W(LK_W)) u_lock (
    .clk, .rst,
    .update  (dump),
    .sum_i, .sum_q,
    .win_len (lock_len),
    .thr_hi  (lock_hi),
    .thr_lo  (lock_lo),
    .locked
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid     <= 1'b0;
      m_soft_i    <= '0;
      m_phase_err <= '0;
    end else if (dump) begin
      m_valid     <= 1'b1;
      m_soft_i    <= sum_i;
      m_phase_err <= err;
    end else if (m_ready) begin
      m_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/costas_carrier_loop_chk.sv
module costas_carrier_loop_chk #(
  parameter int INT_W   = 32,
  parameter int PHASE_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    s_ready,
  input logic                    m_valid,
  input logic                    m_ready,
  input logic signed [INT_W-1:0] m_soft_i,
  input logic signed [INT_W-1:0] m_phase_err,
  input logic                    locked,
  input logic                    accept,
  input logic                    dump,
  input logic [PHASE_W-1:0]      nco_phase,
  input logic [PHASE_W-1:0]      loop_integ
);
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    dump |=> m_valid);

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_soft_i) && $stable(m_phase_err)));

  p_phase_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(nco_phase));

  p_integ_only_dump_r7: assert property (@(posedge clk) disable iff (rst)
    !dump |=> $stable(loop_integ));

  p_lock_only_dump_r9: assert property (@(posedge clk) disable iff (rst)
    !dump |=> $stable(locked));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (nco_phase == '0 && loop_integ == '0 && !locked && !m_valid));
endmodule

bind costas_carrier_loop costas_carrier_loop_chk #(.INT_W(INT_W), .PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/costas_carrier_loop_tb.sv
`timescale 1ns/1ps
module costas_carrier_loop_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic [4:0]  kp_shift = 5'd31, ki_shift = 5'd31;
  logic [7:0]  lock_len = 8'd1;
  logic signed [40:0] lock_hi = '0, lock_lo = '0;
  logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b1;
  logic signed [11:0] s_sample = '0;
  logic s_ready, m_valid, locked;
  logic signed [31:0] m_soft_i, m_phase_err;

  always #2.5 clk = ~clk;

  costas_carrier_loop u_dut (
    .clk, .rst, .freq_word, .kp_shift, .ki_shift, .lock_len, .lock_hi, .lock_lo,
    .s_valid, .s_ready, .s_sample, .s_last,
    .m_valid, .m_ready, .m_soft_i, .m_phase_err, .locked
  );

  int n_checks = 0, n_errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model state
  typedef struct { int si; int e; bit l; } item_t;
  item_t exp_q[$];
  logic [31:0] m_phase;
  int m_integ, m_prop, m_acc_i, m_acc_q, m_cnt;
  longint m_lk_acc;
  bit m_lock;
  int last_i, last_err;
  bit last_lock;

  function automatic int sine_ref(input int k);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
    if (v >= 0.0) return int'($floor(v + 0.5));
    return -int'($floor(-v + 0.5));
  endfunction

  task automatic model_reset();
    m_phase = '0; m_integ = 0; m_prop = 0; m_acc_i = 0; m_acc_q = 0;
    m_cnt = 0; m_lk_acc = 0; m_lock = 1'b0;
  endtask

  task automatic model_step(input int x, input bit last);
    int k, c, s, si, sq, err, p1, p2, len;
    longint diff, total;
    item_t it;
    k  = int'(m_phase[31:26]);
    c  = sine_ref((k + 16) % 64);
    s  = sine_ref(k);
    si = m_acc_i + x * c;
    sq = m_acc_q - x * s;
    m_phase = m_phase + freq_word + m_integ + m_prop;
    if (last) begin
      err = (si < 0) ? -sq : sq;
      m_prop  = err >>> kp_shift;
      m_integ = m_integ + (err >>> ki_shift);
      p1 = si >>> 16;
      p2 = sq >>> 16;
      diff  = longint'(p1 * p1) - longint'(p2 * p2);
      total = m_lk_acc + diff;
      len = int'(lock_len);
      if (m_cnt + 1 >= len) begin
        m_lk_acc = 0; m_cnt = 0;
        if (total > longint'(lock_hi)) m_lock = 1'b1;
        else if (total < longint'(lock_lo)) m_lock = 1'b0;
      end else begin
        m_lk_acc = total; m_cnt++;
      end
      m_acc_i = 0; m_acc_q = 0;
      it.si = si; it.e = err; it.l = m_lock;
      exp_q.push_back(it);
    end else begin
      m_acc_i = si; m_acc_q = sq;
    end
  endtask

  // Driver: offers one sample, model updates on the consuming edge
  task automatic send(input int x, input bit last);
    @(negedge clk);
    s_valid = 1'b1; s_sample = 12'(x); s_last = last;
    forever begin
      #1;
      if (s_ready) begin
        model_step(x, last);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    idle(2);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    #1.5;
    if (!rst && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected result beat", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(m_soft_i == it.si, "R5 scoreboard soft I", m_soft_i, it.si);
        check(m_phase_err == it.e, "R6/R7 scoreboard phase error", m_phase_err, it.e);
        check(locked == it.l, "R8 scoreboard lock", locked, it.l);
      end
      last_i = m_soft_i; last_err = m_phase_err; last_lock = locked;
    end
  end

  task automatic symbol4(input int a0, input int a1, input int a2, input int a3, input int groups);
    for (int g = 0; g < groups; g++) begin
      send(a0, 1'b0); send(a1, 1'b0); send(a2, 1'b0); send(a3, g == groups - 1);
    end
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 5.0);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int held;
    model_reset();
    do_reset();
    #1;
    check(m_valid == 1'b0, "R10 m_valid after reset", m_valid, 0);
    check(locked == 1'b0, "R10 locked after reset", locked, 0);
    check(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);

    // Carrier at DC: cos(0)=127, sin(0)=0
    freq_word = 32'h0; kp_shift = 5'd31; ki_shift = 5'd31; lock_len = 8'd1;
    lock_hi = 41'sd1000000000; lock_lo = -41'sd1000000000;
    for (int n = 0; n < 32; n++) send(1000, n == 31);
    settle();
    check(last_i == 4064000, "R4/R5 DC soft I", last_i, 4064000);
    check(last_err == 0, "R6 DC zero quadrature", last_err, 0);
    for (int n = 0; n < 32; n++) send(-1000, n == 31);
    settle();
    check(last_i == -4064000, "R5 DC negative soft I", last_i, -4064000);

    // Quarter-turn steps: cos 127,0,-127,0 and sin 0,127,0,-127
    do_reset();
    freq_word = 32'h4000_0000; lock_len = 8'd4;
    lock_hi = 41'sd20000; lock_lo = -41'sd20000;
    symbol4(1500, 0, -1500, 0, 16);
    symbol4(1500, 0, -1500, 0, 16);
    symbol4(-1500, 0, 1500, 0, 16);
    settle();
    check(locked == 1'b0, "R9 lock unchanged inside window", locked, 0);
    symbol4(1500, 0, -1500, 0, 16);
    settle();
    check(locked == 1'b1, "R8 lock set above high threshold", locked, 1);
    check(last_i == 6096000, "R5 quarter soft I", last_i, 6096000);
    for (int s = 0; s < 4; s++) symbol4(0, -1500, 0, 1500, 16);
    settle();
    check(last_i == 0, "R5 quadrature-only soft I", last_i, 0);
    check(last_err == 6096000, "R6 error equals Q when I is zero", last_err, 6096000);
    check(locked == 1'b0, "R8 lock cleared below low threshold", locked, 0);
    for (int s = 0; s < 4; s++) symbol4(-1500, 1500, 1500, -1500, 16);
    settle();
    check(last_i == -6096000, "R5 negative in-phase sum", last_i, -6096000);
    check(last_err == 6096000, "R6 error negated for negative I", last_err, 6096000);
    check(locked == 1'b0, "R8 lock holds between thresholds", locked, 0);

    // Back-pressure
    m_ready = 1'b0;
    symbol4(1500, 0, -1500, 0, 2);
    idle(1);
    #1;
    held = m_soft_i;
    check(m_valid == 1'b1, "R1 result valid after symbol end", m_valid, 1);
    fork
      send(700, 1'b0);
      begin
        for (int c = 0; c < 4; c++) begin
          @(negedge clk); #1;
          check(s_ready == 1'b0, "R2 input stalled while result held", s_ready, 0);
          check(m_valid == 1'b1 && m_soft_i == held, "R2 result held", m_soft_i, held);
        end
        @(negedge clk);
        m_ready = 1'b1;
      end
    join
    send(700, 1'b0); send(-700, 1'b0); send(0, 1'b1);
    settle();

    // Tracking run with active loop gains, idles and varied lengths
    do_reset();
    freq_word = 32'h0A3D_70A4; kp_shift = 5'd6; ki_shift = 5'd14; lock_len = 8'd3;
    lock_hi = 41'sd5000; lock_lo = 41'sd1000;
    lfsr = 16'hACE1;
    begin
      int n;
      n = 0;
      for (int s = 0; s < 36; s++) begin
        int len, d;
        len = 20 + int'(lfsr[5:0]) % 50;
        d = lfsr[9] ? 1 : -1;
        for (int j = 0; j < len; j++) begin
          int x;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          x = int'(1400.0 * d * $cos(2.0 * 3.14159265358979 * 0.04 * n)) + ($signed(lfsr[11:0]) >>> 3);
          n++;
          send(x, j == len - 1);
          if (lfsr[2:0] == 3'd0) idle(1);
        end
      end
    end
    settle();
    check(exp_q.size() == 0, "R3/R7 all tracking results delivered", exp_q.size(), 0);

    // One-sample symbols: load and drain on the same edge, lock window of one
    lock_len = 8'd0; lock_hi = 41'sd0; lock_lo = 41'sd0;
    for (int s = 0; s < 6; s++) send((s % 2) ? -1800 : 1800, 1'b1);
    for (int s = 0; s < 6; s++) send((s % 2) ? 1200 : -900, 1'b1);
    settle();
    check(exp_q.size() == 0, "R1 back-to-back results all delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule